// File: doc/BRIEF.md
# Two-Cycle Port I/O Sequencer

This block sequences the external port bus of a small microcontroller in which every instruction takes two clock cycles. The execute stage hands it one port operation at a time. Each operation is a read or a write, and it uses either a direct or an indirect port number. A direct operation carries a 5-bit port number from the instruction word, so it reaches ports 0 to 31. An indirect operation carries a full 8-bit port number taken from a register, so it reaches ports 0 to 255.

Every operation lasts two cycles on the port bus. In the first cycle the port address appears on the bus and both strobes stay low. In the second cycle the address is still held. In that cycle a read raises the read strobe and the block samples the input bus at the closing clock edge. A write raises the write strobe and drives the output data in the same cycle. The byte sampled by a read is returned to the register write-back path for one cycle with a valid flag.

Requests arrive on a valid/ready channel. The block lowers `req_ready` during the first cycle of an operation, which holds the request back. It raises `req_ready` in the second cycle, so a new operation can follow with no idle cycle between them. A request offered while `req_ready` is low stays pending and is not lost. The write-back output has no back-pressure: the register file takes `rd_valid` on the cycle it is raised.

Top module: `pio_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `io_rd`, `io_wr` and `rd_valid` are 0, `io_addr` and `io_dout` are 0, and `req_ready` is 1.
- R2: For a direct operation (`req_indirect`=0), `io_addr` is `req_imm` zero-extended to 8 bits (bits 7..5 are 0). `req_reg` has no effect on the address.
- R3: For an indirect operation (`req_indirect`=1), `io_addr` equals the 8-bit `req_reg` value captured at acceptance. `req_imm` has no effect on the address.
- R4: The port address is driven in both cycles of an operation and does not change between them. `io_addr` is 0 when no operation is in progress.
- R5: For a read (`req_write`=0), `io_rd` is high for exactly one cycle, the second cycle of the operation, and `io_wr` stays low throughout.
- R6: For a write (`req_write`=1), `io_wr` is high for exactly one cycle, the second cycle, and in that cycle `io_dout` carries the captured `req_wdata`. `io_dout` is 0 whenever `io_wr` is low.
- R7: The cycle after a read's strobe cycle, `rd_valid` is high for one cycle and `rd_data` equals the `io_din` value present during the strobe cycle. A write never raises `rd_valid`.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the first cycle of an operation and 1 when idle and in the second cycle. A request accepted in the second cycle starts its own first cycle on the next cycle.
- R9: `io_rd` and `io_wr` are never high together, and both are low in any cycle that is not the second cycle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Port operation offered |
| req_ready | output | 1 | Sequencer can take an operation this cycle |
| req_write | input | 1 | 1 = write to port, 0 = read from port |
| req_indirect | input | 1 | 1 = port number from register, 0 = from instruction field |
| req_imm | input | 5 | Direct port number from the instruction |
| req_reg | input | 8 | Register value used as port number for indirect operations |
| req_wdata | input | 8 | Byte to write |
| io_addr | output | 8 | Port address bus |
| io_dout | output | 8 | Port output data bus |
| io_rd | output | 1 | Read strobe |
| io_wr | output | 1 | Write strobe |
| io_din | input | 8 | Port input data bus |
| rd_valid | output | 1 | Read result valid for register write-back |
| rd_data | output | 8 | Byte sampled from the port |

## Verification
The bound checker checks on every cycle that the strobes are never high together and last only one cycle, and that the address is unchanged between an operation's two cycles. It also checks that a strobe only follows a cycle with `req_ready` low, that `io_dout` is 0 outside write strobes, that a read result matches the input byte from the strobe cycle, and that direct and indirect addresses are formed from the accepted request. Only the bench scenarios can show the full picture. They sweep every direct and every indirect port number in both directions with varied data. They also confirm that the unused port-number field has no effect, that a write returns no result, and that a request held pending during the first cycle is taken in the second cycle with no gap.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2
  } pio_phase_e;

endpackage

// File: rtl/pio_addr_sel.sv
module pio_addr_sel #(
  parameter int ADDR_W   = 8,
  parameter int DIRECT_W = 5
) (
  input  logic                indirect,
  input  logic [DIRECT_W-1:0] imm,
  input  logic [ADDR_W-1:0]   regval,
  output logic [ADDR_W-1:0]   addr
);

  localparam int PAD_W = ADDR_W - DIRECT_W;

  logic [ADDR_W-1:0] direct_addr;

  generate
    if (PAD_W > 0) begin : g_pad
      assign direct_addr = {{PAD_W{1'b0}}, imm};
    end else begin : g_nopad
      assign direct_addr = imm[ADDR_W-1:0];
    end
  endgenerate

  assign addr = indirect ? regval : direct_addr;

endmodule

// File: rtl/pio_phase_ctl.sv
module pio_phase_ctl
  import pio_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic busy,
  output logic in_strobe
);

  pio_phase_e phase_q, phase_d;

  assign req_ready = (phase_q != PH_SETUP);
  assign accept    = req_valid && req_ready;
  assign busy      = (phase_q != PH_IDLE);
  assign in_strobe = (phase_q == PH_STROBE);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   phase_d = accept ? PH_SETUP : PH_IDLE;
      PH_SETUP:  phase_d = PH_STROBE;
      PH_STROBE: phase_d = accept ? PH_SETUP : PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/pio_op_regs.sv
module pio_op_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              write_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              write_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= write_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

endmodule

// File: rtl/pio_rd_capture.sv
module pio_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] din,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= din;
    end
  end

endmodule

// File: rtl/pio_seq.sv
module pio_seq #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int DIRECT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_indirect,
  input  logic [DIRECT_W-1:0] req_imm,
  input  logic [ADDR_W-1:0]   req_reg,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [ADDR_W-1:0]   io_addr,
  output logic [DATA_W-1:0]   io_dout,
  output logic                io_rd,
  output logic                io_wr,
  input  logic [DATA_W-1:0]   io_din,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);

  logic              accept;
  logic              busy;
  logic              in_strobe;
  logic [ADDR_W-1:0] sel_addr;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  pio_phase_ctl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .busy      (busy),
    .in_strobe (in_strobe)
  );

  pio_addr_sel #(.ADDR_W(ADDR_W), .DIRECT_W(DIRECT_W)) u_addr (
    .indirect (req_indirect),
    .imm      (req_imm),
    .regval   (req_reg),
    .addr     (sel_addr)
  );

  pio_op_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .write_in (req_write),
    .addr_in  (sel_addr),
    .wdata_in (req_wdata),
    .write_q  (write_q),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q)
  );

  assign io_addr = busy ? addr_q : '0;
  assign io_rd   = in_strobe && !write_q;
  assign io_wr   = in_strobe && write_q;
  assign io_dout = io_wr ? wdata_q : '0;

  pio_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (io_rd),
    .din       (io_din),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/pio_seq_checker.sv
module pio_seq_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int DIRECT_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_indirect,
  input logic [ADDR_W-1:0]   req_reg,
  input logic [ADDR_W-1:0]   io_addr,
  input logic [DATA_W-1:0]   io_dout,
  input logic                io_rd,
  input logic                io_wr,
  input logic [DATA_W-1:0]   io_din,
  input logic                rd_valid,
  input logic [DATA_W-1:0]   rd_data
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr)); // R9
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> !io_rd); // R5
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> !io_wr); // R6
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |-> io_dout == '0); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> $stable(io_addr)); // R4
  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> $past(!req_ready)); // R8
  AST_RESULT_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> rd_valid); // R7
  AST_RESULT_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(io_rd)); // R7
  AST_RESULT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data == $past(io_din)); // R7
  AST_DIRECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_indirect) |=> (io_addr >> DIRECT_W) == '0); // R2
  AST_INDIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_indirect) |=> io_addr == $past(req_reg)); // R3

endmodule

bind pio_seq pio_seq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIRECT_W(DIRECT_W)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_indirect (req_indirect),
  .req_reg      (req_reg),
  .io_addr      (io_addr),
  .io_dout      (io_dout),
  .io_rd        (io_rd),
  .io_wr        (io_wr),
  .io_din       (io_din),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data)
);

// File: tb/test_pio_seq.sv
`timescale 1ns/1ps
module test_pio_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic       req_indirect = 1'b0;
  logic [4:0] req_imm = '0;
  logic [7:0] req_reg = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] io_addr;
  logic [7:0] io_dout;
  logic       io_rd;
  logic       io_wr;
  logic [7:0] io_din = '0;
  logic       rd_valid;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pio_seq i_pio_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_indirect(req_indirect),
    .req_imm(req_imm), .req_reg(req_reg), .req_wdata(req_wdata),
    .io_addr(io_addr), .io_dout(io_dout), .io_rd(io_rd), .io_wr(io_wr),
    .io_din(io_din), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One complete operation from an idle start; sampling at negedges.
  task automatic do_op(input bit wr, input bit ind, input int imm, input int regv,
                       input int wd, input int din);
    int e;
    e = ind ? (regv & 255) : (imm & 31);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_indirect = ind;
    req_imm = 5'(imm); req_reg = 8'(regv); req_wdata = 8'(wd);
    @(negedge clk);
    req_valid = 1'b0;
    req_imm = 5'(~imm); req_reg = 8'(~regv);
    io_din = 8'(din);
    chk(io_addr == 8'(e), ind ? "R3 addr setup" : "R2 addr setup", int'(io_addr), e);
    chk(!io_rd && !io_wr, "R9 no strobe in setup", int'({io_rd, io_wr}), 0);
    chk(req_ready == 1'b0, "R8 ready low setup", int'(req_ready), 0);
    @(negedge clk);
    chk(io_addr == 8'(e), "R4 addr held", int'(io_addr), e);
    if (wr) begin
      chk(io_wr && !io_rd, "R6 write strobe", int'({io_rd, io_wr}), 1);
      chk(io_dout == 8'(wd), "R6 dout", int'(io_dout), wd & 255);
    end else begin
      chk(io_rd && !io_wr, "R5 read strobe", int'({io_rd, io_wr}), 2);
      chk(io_dout == 8'd0, "R6 dout quiet on read", int'(io_dout), 0);
    end
    chk(req_ready == 1'b1, "R8 ready in strobe", int'(req_ready), 1);
    @(negedge clk);
    io_din = 8'(~din);
    chk(!io_rd && !io_wr, "R9 strobes low after", int'({io_rd, io_wr}), 0);
    chk(io_addr == 8'd0, "R4 addr idle", int'(io_addr), 0);
    chk(rd_valid == !wr, "R7 result valid", int'(rd_valid), int'(!wr));
    if (!wr) chk(rd_data == 8'(din), "R7 result data", int'(rd_data), din & 255);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2;
    // R1 during reset
    chk(!io_rd && !io_wr && !rd_valid, "R1 strobes in reset", int'({io_rd, io_wr, rd_valid}), 0);
    chk(io_addr == 8'd0 && io_dout == 8'd0, "R1 buses in reset", int'(io_addr), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(!io_rd && !io_wr && !rd_valid, "R1 quiet after reset", int'({io_rd, io_wr, rd_valid}), 0);
    chk(io_addr == 8'd0, "R1 addr after reset", int'(io_addr), 0);

    // R2: every direct port, both directions, register field set to noise
    for (int p = 0; p < 32; p++) begin
      do_op(1'b0, 1'b0, p, 255 - p, 0, (p * 37 + 11) & 255);
      do_op(1'b1, 1'b0, p, 255 - p, (p * 13 + 5) & 255, 0);
    end
    // R3: every indirect port, both directions, immediate field set to noise
    for (int p = 0; p < 256; p++) begin
      do_op(1'b0, 1'b1, (p ^ 5) & 31, p, 0, (p * 91 + 7) & 255);
      do_op(1'b1, 1'b1, (p ^ 9) & 31, p, (255 - p) * 3 & 255, 0);
    end

    // R8: back-to-back, request held pending through the setup cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_indirect = 1'b1; req_reg = 8'h9C; req_imm = 5'd3;
    @(negedge clk);
    chk(req_ready == 1'b0, "R8 ready low b2b", int'(req_ready), 0);
    req_write = 1'b1; req_indirect = 1'b0; req_imm = 5'd17; req_reg = 8'hEE; req_wdata = 8'h3C;
    io_din = 8'h5A;
    @(negedge clk);
    chk(io_addr == 8'h9C && io_rd, "R8 first op strobe", int'(io_addr), 'h9C);
    chk(req_ready == 1'b1, "R8 ready in strobe b2b", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rd_valid && rd_data == 8'h5A, "R7 b2b result", int'(rd_data), 'h5A);
    chk(io_addr == 8'd17, "R8 second op started", int'(io_addr), 17);
    chk(!io_rd && !io_wr && !req_ready, "R8 second op setup", int'({io_rd, io_wr, req_ready}), 0);
    @(negedge clk);
    chk(io_wr && io_dout == 8'h3C && io_addr == 8'd17, "R6 b2b write", int'(io_dout), 'h3C);
    @(negedge clk);
    chk(!rd_valid && !io_wr && io_addr == 8'd0, "R7 b2b write no result", int'(rd_valid), 0);
    @(negedge clk);
    chk(!io_wr && !io_rd, "R8 single op per request", int'({io_rd, io_wr}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule